// File: doc/BRIEF.md
# Interval and Pulse-Width Timer with Interrupt

This block is an up-counter with a compare register that works in one of two modes. In interval mode the counter runs from zero up to the compare value and then starts again from zero. Each time it wraps this way it sets a sticky match flag. The flag drives a level-sensitive interrupt request while interrupts are enabled. In pulse-width mode the counter wraps freely through its whole range, and an output pin stays high while the count is below the compare value. A match in this mode never raises the flag or an interrupt.

Software reaches the block through a small register port. Address 0 holds the control register, address 1 the compare register, and address 2 is a read-only view of the counter. The count clock comes in as a set of one-cycle tick inputs. A select field in the control register picks one of them, so the prescaler that produces the ticks stays outside this block. The asynchronous reset is released through a two-stage synchronizer.

Top module: `pwm_interval_timer`

## Requirements
- R1: After reset the control register reads 0x00, the compare register reads 0xFF, the counter reads 0x00, and both `irq` and `pwm_out` are low.
- R2: The counter moves only on a clock edge where the run bit is 1 and the tick line chosen by control bits [5:4] is high. Ticks on lines that are not selected have no effect on the counter.
- R3: In interval mode (control bit 3 = 0), a selected tick that arrives while the counter equals the compare value sends the counter to 0x00 and sets the match flag (control bit 2). The flag is set whatever the interrupt-enable bit holds, so the match period is compare+1 ticks.
- R4: Writing 0 to control bit 2 clears the match flag, and writing 1 to it leaves the flag unchanged. If a match and a clearing write fall on the same edge, the flag ends up set.
- R5: While the run bit (control bit 0) is 0, the counter holds its value and the flag is not set, even when the held count equals the compare value and ticks arrive.
- R6: A write that changes the run bit from 0 to 1 loads the counter with 0x00 on that edge.
- R7: `irq` is high exactly when the match flag and the interrupt-enable bit (control bit 1) are both 1. When the enable is written from 0 to 1 while the flag is already set, `irq` is high in the very next cycle.
- R8: In pulse-width mode (control bit 3 = 1), the counter wraps from 0xFF to 0x00. `pwm_out` is high while the count is below the compare value and low otherwise, so a compare value of 0x00 keeps it low. A match never sets the flag, so `irq` stays low.
- R9: Register writes take effect on the clock edge where `wr_en` is sampled high. Reads are combinational on `addr`, with address 0 for control, 1 for compare and 2 for the counter. Control bits [7:6] read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register address: 0 control, 1 compare, 2 counter |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| tick_in | input | 4 | Count-clock tick lines, one of which is picked by the select field |
| pwm_out | output | 1 | Pulse-width output |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
Every result of this block is decided by the flops at a single clock edge. A register write or a selected tick sampled at edge N is visible on `rdata`, `irq` and `pwm_out` just after edge N, and none of them takes an extra pipeline cycle. For that reason the bench drives its inputs on the falling edge and updates its reference model on the rising edge with the same sampled inputs. It compares `irq` and `pwm_out` against the model on the next falling edge. Register reads set `addr` on a falling edge and sample `rdata` 1 ns later, so the combinational read path has settled and no rising edge has happened yet. This way the enable-while-pending case and a match on the same edge as a clearing write are each checked in the exact cycle they are due.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  // Control register bit positions
  localparam int BIT_RUN  = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_FLAG = 2;
  localparam int BIT_MODE = 3;
  localparam int SEL_LSB  = 4;

  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_PWM      = 1'b1
  } tmode_e;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             match_evt,
  output logic             run,
  output logic             ie,
  output logic             flag,
  output tmode_e           mode,
  output logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cmp,
  output logic             start
);
  logic             wr_ctrl, wr_cmp;
  logic             run_nxt, ie_nxt, flag_nxt;
  tmode_e           mode_nxt;
  logic [SEL_W-1:0] sel_nxt;
  logic [CNT_W-1:0] cmp_nxt;

  assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
  assign wr_cmp  = wr_en && (addr == ADDR_CMP);
  assign start   = wr_ctrl && wdata[BIT_RUN] && !run;

  always_comb begin
    run_nxt  = run;
    ie_nxt   = ie;
    mode_nxt = mode;
    sel_nxt  = sel;
    cmp_nxt  = cmp;
    flag_nxt = flag;
    if (wr_ctrl) begin
      run_nxt  = wdata[BIT_RUN];
      ie_nxt   = wdata[BIT_IE];
      mode_nxt = tmode_e'(wdata[BIT_MODE]);
      sel_nxt  = wdata[SEL_LSB +: SEL_W];
      if (!wdata[BIT_FLAG]) flag_nxt = 1'b0;
    end
    if (wr_cmp) cmp_nxt = wdata;
    if (match_evt) flag_nxt = 1'b1;  // hardware set beats software clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      ie   <= 1'b0;
      flag <= 1'b0;
      mode <= MODE_INTERVAL;
      sel  <= '0;
      cmp  <= '1;
    end else begin
      run  <= run_nxt;
      ie   <= ie_nxt;
      flag <= flag_nxt;
      mode <= mode_nxt;
      sel  <= sel_nxt;
      cmp  <= cmp_nxt;
    end
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  tmode_e           mode,
  input  logic             start,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             match_evt,
  output logic             pwm_out
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;

  assign step = run && tick;

  always_comb begin
    cnt_nxt   = cnt;
    match_evt = 1'b0;
    if (start) begin
      cnt_nxt = '0;
    end else if (step) begin
      if (mode == MODE_INTERVAL && cnt == cmp) begin
        cnt_nxt   = '0;
        match_evt = 1'b1;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign pwm_out = (mode == MODE_PWM) && (cnt < cmp);
endmodule

// File: rtl/pwm_interval_timer.sv
module pwm_interval_timer
  import timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int N_TICK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic [N_TICK-1:0] tick_in,
  output logic              pwm_out,
  output logic              irq
);
  localparam int SEL_W = (N_TICK > 1) ? $clog2(N_TICK) : 1;
  localparam int PAD_W = CNT_W - SEL_LSB - SEL_W;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             run, ie, flag, start, match_evt, tick_sel;
  tmode_e           mode;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] cmp, cnt, ctrl_rd;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign tick_sel = tick_in[sel];

  timer_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .match_evt(match_evt), .run(run), .ie(ie), .flag(flag), .mode(mode),
    .sel(sel), .cmp(cmp), .start(start)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .run(run), .tick(tick_sel), .mode(mode),
    .start(start), .cmp(cmp), .cnt(cnt), .match_evt(match_evt),
    .pwm_out(pwm_out)
  );

  assign ctrl_rd = {{PAD_W{1'b0}}, sel, mode, flag, ie, run};

  always_comb begin
    case (addr)
      ADDR_CTRL: rdata = ctrl_rd;
      ADDR_CMP:  rdata = cmp;
      ADDR_CNT:  rdata = cnt;
      default:   rdata = '0;
    endcase
  end

  assign irq = flag && ie;
endmodule

// File: rtl/timer_chk.sv
module timer_chk
  import timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ctrl,
  input logic             wflag,
  input logic             run,
  input logic             ie,
  input logic             flag,
  input logic             pmode,
  input logic             start,
  input logic             tick_sel,
  input logic [CNT_W-1:0] cmp,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             pwm_out
);
  logic hit;
  assign hit = run && tick_sel && !pmode && (cnt == cmp) && !start;

  // R3
  interval_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0) && flag);

  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(cnt));

  // R5
  stop_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !flag) |=> !flag);

  // R8
  pwm_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode && !flag && !wr_ctrl) |=> !flag);

  // R7
  irq_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ie) && flag) |-> irq);

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wflag && !hit) |=> !flag);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0));

  // R8
  pwm_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == '0) |-> !pwm_out);
endmodule

bind pwm_interval_timer timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n),
  .wr_ctrl(wr_en && (addr == timer_pkg::ADDR_CTRL)),
  .wflag(wdata[timer_pkg::BIT_FLAG]),
  .run(run), .ie(ie), .flag(flag), .pmode(mode == timer_pkg::MODE_PWM),
  .start(start), .tick_sel(tick_sel), .cmp(cmp), .cnt(cnt),
  .irq(irq), .pwm_out(pwm_out)
);

// File: tb/test_pwm_interval_timer.sv
`timescale 1ns/1ps
module test_pwm_interval_timer;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] tick_in;
  logic       pwm_out, irq;
  logic       tick_on = 1'b0;
  int         tick_line = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_cnt, m_cmp, m_run, m_ie, m_flag, m_mode, m_sel;

  assign tick_in = tick_on ? (4'b0001 << tick_line) : 4'b0000;

  always #HALF clk = ~clk;

  pwm_interval_timer i_pwm_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_in(tick_in), .pwm_out(pwm_out), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 255; m_run = 0; m_ie = 0; m_flag = 0; m_mode = 0; m_sel = 0;
    end else begin
      bit t, wc, started, ev;
      int nc;
      t       = tick_in[m_sel];
      wc      = wr_en && addr == 2'd0;
      started = wc && wdata[0] && m_run == 0;
      ev      = 0;
      nc      = m_cnt;
      if (started) nc = 0;
      else if (m_run != 0 && t) begin
        if (m_mode == 0 && m_cnt == m_cmp) begin nc = 0; ev = 1; end
        else nc = (m_cnt + 1) % 256;
      end
      if (wc) begin
        m_run = wdata[0]; m_ie = wdata[1]; m_mode = wdata[3]; m_sel = wdata[5:4];
        if (!wdata[2]) m_flag = 0;
      end
      if (wr_en && addr == 2'd1) m_cmp = wdata;
      if (ev) m_flag = 1;
      m_cnt = nc;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, R7 and R8 outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "irq per cycle (R7)", irq, (m_flag != 0 && m_ie != 0) ? 1 : 0);
      check(cur_req, "pwm_out per cycle (R8)", pwm_out,
            (m_mode != 0 && m_cnt < m_cmp) ? 1 : 0);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, $sformatf("read addr %0d", a), rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_on = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    tick_on = 1'b0;
  endtask

  initial begin
    #(2 * HALF * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    cur_req = "R1";
    rd(2'd0, 8'h00, "R1");
    rd(2'd1, 8'hFF, "R1");
    rd(2'd2, 8'h00, "R1");
    check("R1", "irq", irq, 0);
    check("R1", "pwm_out", pwm_out, 0);

    // R3 interval match, interrupt disabled
    cur_req = "R3";
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h01);
    rd(2'd2, 8'h00, "R6");
    ticks(4);
    rd(2'd2, 8'h00, "R3");
    rd(2'd0, 8'h05, "R3");
    check("R3", "irq with ie=0", irq, 0);

    // R7 enable while pending
    cur_req = "R7";
    wr(2'd0, 8'h07);
    check("R7", "irq after enable", irq, 1);
    rd(2'd0, 8'h07, "R7");

    // R4 clear and write-one-no-effect
    cur_req = "R4";
    wr(2'd0, 8'h03);
    rd(2'd0, 8'h03, "R4");
    check("R4", "irq after clear", irq, 0);
    wr(2'd0, 8'h07);
    rd(2'd0, 8'h03, "R4");

    // R2 count, R5 stop at match
    cur_req = "R5";
    ticks(3);
    rd(2'd2, 8'h03, "R2");
    wr(2'd0, 8'h02);
    ticks(2);
    rd(2'd2, 8'h03, "R5");
    rd(2'd0, 8'h02, "R5");

    // R6 restart
    cur_req = "R6";
    wr(2'd0, 8'h03);
    rd(2'd2, 8'h00, "R6");

    // R4 match and clearing write on the same edge
    cur_req = "R4";
    ticks(3);
    @(negedge clk);
    tick_on = 1'b1;
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h03;
    @(negedge clk);
    wr_en = 1'b0; tick_on = 1'b0;
    rd(2'd0, 8'h07, "R4");
    rd(2'd2, 8'h00, "R4");
    check("R4", "irq after same-edge set", irq, 1);
    wr(2'd0, 8'h03);

    // R2 tick select
    cur_req = "R2";
    tick_line = 2;
    ticks(3);
    rd(2'd2, 8'h00, "R2");
    wr(2'd0, 8'h23);
    ticks(2);
    rd(2'd2, 8'h02, "R2");

    // R8 pulse-width mode
    cur_req = "R8";
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h2B);
    hi = 0;
    @(negedge clk);
    tick_on = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    tick_on = 1'b0;
    check("R8", "high cycles per wrap, compare 4", hi, 4);
    rd(2'd2, 8'h00, "R8");
    rd(2'd0, 8'h2B, "R8");
    check("R8", "irq in pwm mode", irq, 0);

    wr(2'd1, 8'h00);
    hi = 0;
    @(negedge clk);
    tick_on = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    tick_on = 1'b0;
    check("R8", "high cycles, compare 0", hi, 0);

    // R9 unused control bits read 0
    cur_req = "R9";
    wr(2'd0, 8'hC0);
    rd(2'd0, 8'h00, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule